// File: doc/BRIEF.md
# Residue-to-Binary Converter (Chinese Remainder Theorem)

This block turns a value held as three residues, one for each of the pairwise coprime moduli 10, 9 and 7, back into an ordinary unsigned binary integer in the range 0 to 629. The product of the moduli, 630, is the dynamic range. Each residue is multiplied by a fixed weight: the cofactor of its modulus, times that cofactor's multiplicative inverse modulo the modulus. The weights come out as 441, 280 and 540 for the 10, 9 and 7 lanes. The three products are summed, and the sum is reduced modulo 630 by a short chain of conditional subtractions of 630 times a power of two. No divider is used.

A producer presents the residues together with `in_valid`. The result appears two clock cycles later with `out_valid` high, and a new set of residues may be accepted on every cycle. Any residue that is not smaller than its own modulus marks the conversion as invalid. A value whose true magnitude lies outside the range comes out aliased modulo 630. The moduli are parameters, and the weights, widths and reduction depth are derived from them when the block is built.

Top module: `crt_residue_to_bin`

## Requirements
- R1: For valid residues (ra, rb, rc) the output `out_value` is the unique X in [0, 630) with X mod 10 = ra, X mod 9 = rb and X mod 7 = rc.
- R2: When `in_valid` is sampled high on a clock edge, `out_valid` is high after exactly the second following edge, and it is low after that first edge if no input was taken on the edge before.
- R3: `out_valid` is low two edges after any edge where `in_valid` was low, and back-to-back inputs on consecutive cycles each produce one result on consecutive cycles, in order.
- R4: Whenever `out_valid` is high, `out_value` lies in [0, 629].
- R5: A residue greater than or equal to its own modulus (ra >= 10, rb >= 9 or rc >= 7) makes `out_err` high together with `out_valid` for that result, and `out_value` is 0 for that result. A residue equal to its modulus already counts as invalid.
- R6: While `rst_n` is low, and at the first sample after release, `out_valid`, `out_err` and `out_value` are all 0.
- R7: While no result is delivered (`out_valid` low), `out_value` and `out_err` keep their last values, whatever the residue inputs do.
- R8: The corner values convert exactly: all-zero residues give 0, and residues (9, 8, 6) give 629.
- R9: Residues taken from a true magnitude of 630 or more come out wrapped modulo 630; the residues (5, 7, 2) of 835 give 205.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Residue set is presented this cycle |
| res_a | input | 4 | Residue for modulus 10 |
| res_b | input | 4 | Residue for modulus 9 |
| res_c | input | 4 | Residue for modulus 7 |
| out_valid | output | 1 | Result available this cycle |
| out_err | output | 1 | Result came from an out-of-range residue |
| out_value | output | 10 | Binary integer in [0, 629] |

## Verification
On every cycle the embedded properties check the two-cycle handshake timing, the range bound on the reduced value, and the hold of the outputs between results. They also map each valid result back through the three moduli and compare it with the residues taken two edges earlier, and they check that an invalid residue produces the error flag and a zero value. Only the directed scenarios can show several other behaviours. These are the exhaustive agreement with the integers 0 to 629 under full-rate streaming, the exact corner values 0 and 629, the wrapped result for a magnitude above the range, and the boundary where a residue equal to its modulus turns invalid. Expected values in those scenarios come from a brute-force search over the range.

// File: rtl/crt_residue_to_bin.sv
module crt_residue_to_bin #(
  parameter int MOD_A = 10,
  parameter int MOD_B = 9,
  parameter int MOD_C = 7,
  parameter int RW    = 4
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      in_valid,
  input  logic [RW-1:0]                             res_a,
  input  logic [RW-1:0]                             res_b,
  input  logic [RW-1:0]                             res_c,
  output logic                                      out_valid,
  output logic                                      out_err,
  output logic [$clog2(MOD_A*MOD_B*MOD_C)-1:0]      out_value
);

  function automatic int inv_mod(input int a, input int m);
    int r;
    r = 0;
    for (int k = 1; k < m; k++)
      if (((a * k) % m) == 1 && r == 0) r = k;
    return r;
  endfunction

  localparam int RANGE   = MOD_A * MOD_B * MOD_C;
  localparam int OW      = $clog2(RANGE);
  localparam int CO_A    = RANGE / MOD_A;
  localparam int CO_B    = RANGE / MOD_B;
  localparam int CO_C    = RANGE / MOD_C;
  localparam int WGT_A   = CO_A * inv_mod(CO_A % MOD_A, MOD_A);
  localparam int WGT_B   = CO_B * inv_mod(CO_B % MOD_B, MOD_B);
  localparam int WGT_C   = CO_C * inv_mod(CO_C % MOD_C, MOD_C);
  localparam int SUM_MAX = (MOD_A - 1) * WGT_A + (MOD_B - 1) * WGT_B + (MOD_C - 1) * WGT_C;
  localparam int SUM_W   = $clog2(SUM_MAX + 1);
  localparam int QB      = $clog2(SUM_MAX / RANGE + 1);

  logic             v1_q, e1_q;
  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] val_q;
  logic             bad_in;
  logic [SUM_W-1:0] sum_d;
  logic [SUM_W-1:0] rem [QB:0];

  assign bad_in = (32'(res_a) >= MOD_A) || (32'(res_b) >= MOD_B) || (32'(res_c) >= MOD_C);
  assign sum_d  = SUM_W'(res_a) * SUM_W'(WGT_A)
                + SUM_W'(res_b) * SUM_W'(WGT_B)
                + SUM_W'(res_c) * SUM_W'(WGT_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      e1_q  <= 1'b0;
      sum_q <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        e1_q  <= bad_in;
        sum_q <= sum_d;
      end
    end
  end

  assign rem[QB] = sum_q;
  for (genvar k = QB - 1; k >= 0; k--) begin : g_reduce
    localparam logic [SUM_W-1:0] STEP = SUM_W'(RANGE * (2 ** k));
    assign rem[k] = (rem[k+1] >= STEP) ? rem[k+1] - STEP : rem[k+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      val_q     <= '0;
    end else begin
      out_valid <= v1_q;
      if (v1_q) begin
        out_err <= e1_q;
        val_q   <= e1_q ? '0 : rem[0];
      end
    end
  end

  assign out_value = val_q[OW-1:0];

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  assert_idle_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
  assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (val_q < SUM_W'(RANGE)));
  assert_residue_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |->
      ((32'(out_value) % MOD_A) == 32'($past(res_a, 2)) &&
       (32'(out_value) % MOD_B) == 32'($past(res_b, 2)) &&
       (32'(out_value) % MOD_C) == 32'($past(res_c, 2))));
  assert_bad_residue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((32'(res_a) >= MOD_A) || (32'(res_b) >= MOD_B) || (32'(res_c) >= MOD_C)))
      |-> ##2 (out_err && out_value == '0));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_value) && $stable(out_err)));

endmodule

// File: tb/crt_residue_to_bin_tb.sv
`timescale 1ns/1ps
module crt_residue_to_bin_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] res_a = '0, res_b = '0, res_c = '0;
  logic       out_valid, out_err;
  logic [9:0] out_value;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  crt_residue_to_bin u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .res_a(res_a), .res_b(res_b), .res_c(res_c),
    .out_valid(out_valid), .out_err(out_err), .out_value(out_value)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int search(input int a, input int b, input int c);
    for (int x = 0; x < 630; x++)
      if (x % 10 == a && x % 9 == b && x % 7 == c) return x;
    return -1;
  endfunction

  task automatic single(input int a, input int b, input int c, input int exp_v,
                        input bit exp_e, input string req);
    @(negedge clk);
    res_a = 4'(a); res_b = 4'(b); res_c = 4'(c); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b0, "R2 early", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 valid", int'(out_valid), 1);
    check(out_err == exp_e, {req, " err"}, int'(out_err), int'(exp_e));
    check(int'(out_value) == exp_v, {req, " value"}, int'(out_value), exp_v);
    @(negedge clk);
    check(out_valid == 1'b0, "R3 single pulse", int'(out_valid), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R6 valid", int'(out_valid), 0);
    check(out_err == 1'b0, "R6 err", int'(out_err), 0);
    check(out_value == 10'd0, "R6 value", int'(out_value), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_value == 10'd0, "R6 after release", int'(out_value), 0);
  endtask

  task automatic t_corners;
    single(0, 0, 0, 0, 1'b0, "R8 zero");
    single(9, 8, 6, 629, 1'b0, "R8 top");
    single(3, 5, 1, search(3, 5, 1), 1'b0, "R1 mixed");
    single(7, 0, 4, search(7, 0, 4), 1'b0, "R1 mixed2");
  endtask

  task automatic t_alias;
    single(835 % 10, 835 % 9, 835 % 7, 205, 1'b0, "R9 alias 835");
    single(1259 % 10, 1259 % 9, 1259 % 7, 629, 1'b0, "R9 alias 1259");
  endtask

  task automatic t_invalid;
    single(10, 0, 0, 0, 1'b1, "R5 a equal modulus");
    single(1, 9, 2, 0, 1'b1, "R5 b equal modulus");
    single(4, 4, 7, 0, 1'b1, "R5 c equal modulus");
    single(15, 15, 15, 0, 1'b1, "R5 all high");
    single(9, 8, 6, 629, 1'b0, "R5 recovery");
  endtask

  task automatic t_stream;
    for (int i = 0; i < 632; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check(out_valid == 1'b1, "R3 stream valid", int'(out_valid), 1);
        check(int'(out_value) == i - 2 && !out_err, "R1 stream value", int'(out_value), i - 2);
      end
      if (i < 630) begin
        res_a = 4'(i % 10); res_b = 4'(i % 9); res_c = 4'(i % 7); in_valid = 1'b1;
      end else in_valid = 1'b0;
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R3 stream end", int'(out_valid), 0);
  endtask

  task automatic t_hold;
    single(2, 3, 4, search(2, 3, 4), 1'b0, "R7 setup");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      res_a = 4'(k + 11); res_b = 4'(k); res_c = 4'(k + 2);
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R7 no valid", int'(out_valid), 0);
    check(int'(out_value) == search(2, 3, 4), "R7 value held", int'(out_value), search(2, 3, 4));
    check(out_err == 1'b0, "R7 err held", int'(out_err), 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_alias();
    t_invalid();
    t_stream();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule